// File: doc/BRIEF.md
# Oversampled Bus Write-Strobe Generator

This block sits between a slow 6502-class system bus and an attached static RAM. It also holds a small bank-select register. A free-running fast clock samples the bus clock (PHI2), and that fast clock need have no phase relation to it. A synchronizer brings PHI2 into the fast domain, and the block finds its rising edge there. At that edge it captures the address and the read/write line. From then on, all timing is counted in fast-clock cycles.

The write strobe to the memory is not a decode gated by PHI2. It starts a programmable number of fast cycles after the synchronized rising edge and lasts a programmable number of cycles. It therefore ends well before PHI2 falls, while the captured address and the bus data are still valid. Write data is sampled at the end of that window, never at the rising edge. A write to the I/O page with upper address byte 0xD5 loads the bank-select register from the data bus at the end of the window. That register value then forms the upper part of the memory address.

The sequencing is a four-state machine. `ST_IDLE` waits for a synchronized rising edge, which moves it to `ST_DELAY`. `ST_DELAY` counts START_DLY cycles and then moves to `ST_STROBE`. `ST_STROBE` holds the write window for WE_LEN cycles, and its last cycle is the window-end transition to `ST_HOLD`. `ST_HOLD` waits out the rest of the high phase. From `ST_DELAY`, `ST_STROBE` or `ST_HOLD`, a synchronized low PHI2 forces the abort transition back to `ST_IDLE`.

Top module: `bus_write_strobe`

## Requirements
- R1: While rst_n is low, ce_n_o, oe_n_o and we_n_o are 1, and bank_o is 0, whatever PHI2 does.
- R2: Number the fast-clock rising edges k=1,2,… from the first edge at which phi2_i is high. For an access whose address bits [15:14] are 2'b01 (the memory window), ce_n_o goes low after edge k=3.
- R3: For a memory-window write (rw_i=0), we_n_o is low exactly after edges k=START_DLY+3 through k=START_DLY+2+WE_LEN (5 through 13 with defaults), provided phi2_i stays high long enough. It is high after every other edge.
- R4: If phi2_i stays high for at least START_DLY+WE_LEN+3 edges, we_n_o is already high again while phi2_i is still high.
- R5: The address is captured at edge k=3. While ce_n_o is low, mem_addr_o equals {bank_o, captured address[13:0]}, even if addr_i changes later in the cycle.
- R6: A write (rw_i=0) with address bits [15:8]=8'hD5 loads bank_o from data_i as sampled at edge k=START_DLY+WE_LEN+3. Data values present earlier in the cycle have no effect.
- R7: If synchronized PHI2 goes low before the window completes (phi2_i high for fewer than START_DLY+WE_LEN+1 edges), the strobes return high at the next fast edge and bank_o is not loaded.
- R8: we_n_o stays high for reads, for addresses outside the memory window and for the I/O page. oe_n_o stays high for writes.
- R9: For a memory-window read, oe_n_o is low after edges k=3 through k=H+2, where H is the number of edges at which phi2_i was high. ce_n_o follows the same span for any memory-window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running sampling clock |
| rst_n | input | 1 | Active-low reset |
| phi2_i | input | 1 | Bus clock PHI2, asynchronous to clk |
| rw_i | input | 1 | Bus read/write line, 1 = read |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus data for writes |
| ce_n_o | output | 1 | Active-low memory chip enable |
| oe_n_o | output | 1 | Active-low memory read enable |
| we_n_o | output | 1 | Active-low shortened write strobe |
| mem_addr_o | output | DATA_W+ADDR_W-SEL_BITS | Bank register concatenated with captured address offset |
| bank_o | output | DATA_W | Bank-select register |

## Verification
The bench targets PHI2 high phases that end at the edges of the counted window. One of these is one cycle short of the bank-load point, and here a design that loads anyway would corrupt the bank. Another is just long enough, and here a design that counts one cycle too many would miss the load. Bus data changes between the rising edge and the window end, so a design that samples data at the rising edge loads a stale byte. The address lines glitch in the middle of the cycle, so a design that decodes the live bus instead of the captured address would drive a wrong memory address.

// File: rtl/wsg_pkg.sv
`timescale 1ns/1ps
package wsg_pkg;

    // Write-window sequencing states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } win_state_e;

endpackage

// File: rtl/wsg_sync_edge.sv
`timescale 1ns/1ps
module wsg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/wsg_decode.sv
`timescale 1ns/1ps
module wsg_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          SEL_BITS  = 2,
    parameter int unsigned SEL_VAL   = 1,
    parameter int          PAGE_BITS = 8,
    parameter int unsigned IO_PAGE   = 32'hD5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mem_hit_o,
    output logic              io_hit_o
);

    localparam logic [SEL_BITS-1:0]  SEL_MATCH  = SEL_BITS'(SEL_VAL);
    localparam logic [PAGE_BITS-1:0] PAGE_MATCH = PAGE_BITS'(IO_PAGE);

    always_comb begin
        mem_hit_o = (addr_i[ADDR_W-1 -: SEL_BITS] == SEL_MATCH);
        io_hit_o  = (addr_i[ADDR_W-1 -: PAGE_BITS] == PAGE_MATCH);
    end

endmodule

// File: rtl/wsg_window_fsm.sv
`timescale 1ns/1ps
module wsg_window_fsm
    import wsg_pkg::*;
#(
    parameter int START_DLY = 2,
    parameter int WE_LEN    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2_lvl_i,
    input  logic phi2_rise_i,
    input  logic wr_i,
    input  logic mem_hit_i,
    output logic ce_n_o,
    output logic oe_n_o,
    output logic we_n_o,
    output logic win_end_o
);

    localparam int CNT_MAX = (START_DLY > WE_LEN) ? START_DLY : WE_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(START_DLY - 1);
    localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(WE_LEN - 1);
    localparam int RUN_W   = $clog2(WE_LEN + 2);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        win_end_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (phi2_rise_i) begin
                    state_d = ST_DELAY;
                    cnt_d   = '0;
                end
            end
            ST_DELAY: begin
                if (!phi2_lvl_i) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == DLY_LAST) begin
                    state_d = ST_STROBE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (!phi2_lvl_i) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == LEN_LAST) begin
                    state_d   = ST_HOLD;
                    win_end_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (!phi2_lvl_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered, glitch-free strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_o <= 1'b1;
            oe_n_o <= 1'b1;
            we_n_o <= 1'b1;
        end else begin
            ce_n_o <= !((state_d != ST_IDLE) && mem_hit_i);
            oe_n_o <= !((state_d != ST_IDLE) && mem_hit_i && !wr_i);
            we_n_o <= !((state_d == ST_STROBE) && mem_hit_i && wr_i);
        end
    end

    // length of the current low run of the write strobe
    logic [RUN_W-1:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
        end else if (we_n_o) begin
            we_run_q <= '0;
        end else if (we_run_q != '1) begin
            we_run_q <= we_run_q + RUN_W'(1);
        end
    end

    // R2
    rise_enters_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phi2_rise_i |=> (state_q == ST_DELAY));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_run_q <= RUN_W'(WE_LEN));

    // R3
    we_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |-> ($past(state_q) == ST_DELAY));

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2_lvl_i |=> (we_n_o && ce_n_o && oe_n_o));

    // R8
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> oe_n_o);

endmodule

// File: rtl/bus_write_strobe.sv
`timescale 1ns/1ps
module bus_write_strobe #(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          SEL_BITS    = 2,
    parameter int unsigned SEL_VAL     = 1,
    parameter int          PAGE_BITS   = 8,
    parameter int unsigned IO_PAGE     = 32'hD5,
    parameter int          START_DLY   = 2,
    parameter int          WE_LEN      = 9,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 phi2_i,
    input  logic                                 rw_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [DATA_W-1:0]                    data_i,
    output logic                                 ce_n_o,
    output logic                                 oe_n_o,
    output logic                                 we_n_o,
    output logic [DATA_W+ADDR_W-SEL_BITS-1:0]    mem_addr_o,
    output logic [DATA_W-1:0]                    bank_o
);

    localparam int OFF_W = ADDR_W - SEL_BITS;

    logic              phi2_lvl, phi2_rise;
    logic [ADDR_W-1:0] addr_q, addr_eff;
    logic              rw_q, rw_eff;
    logic              mem_hit, io_hit;
    logic              win_end;
    logic [DATA_W-1:0] bank_q;

    wsg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (phi2_i),
        .level_o (phi2_lvl),
        .rise_o  (phi2_rise)
    );

    // address and direction are held from the synchronized rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b1;
        end else if (phi2_rise) begin
            addr_q <= addr_i;
            rw_q   <= rw_i;
        end
    end

    // decode sees the bus in the capture cycle, the held copy afterwards
    assign addr_eff = phi2_rise ? addr_i : addr_q;
    assign rw_eff   = phi2_rise ? rw_i   : rw_q;

    wsg_decode #(
        .ADDR_W    (ADDR_W),
        .SEL_BITS  (SEL_BITS),
        .SEL_VAL   (SEL_VAL),
        .PAGE_BITS (PAGE_BITS),
        .IO_PAGE   (IO_PAGE)
    ) u_decode (
        .addr_i    (addr_eff),
        .mem_hit_o (mem_hit),
        .io_hit_o  (io_hit)
    );

    wsg_window_fsm #(
        .START_DLY (START_DLY),
        .WE_LEN    (WE_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .phi2_lvl_i  (phi2_lvl),
        .phi2_rise_i (phi2_rise),
        .wr_i        (!rw_eff),
        .mem_hit_i   (mem_hit),
        .ce_n_o      (ce_n_o),
        .oe_n_o      (oe_n_o),
        .we_n_o      (we_n_o),
        .win_end_o   (win_end)
    );

    // bank register: loaded from the bus data at the end of the write window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (win_end && !rw_q && io_hit) begin
            bank_q <= data_i;
        end
    end

    assign bank_o     = bank_q;
    assign mem_addr_o = {bank_q, addr_q[OFF_W-1:0]};

    // R6
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_q) |-> $past(!rw_q && io_hit && phi2_lvl));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_q));

endmodule

// File: tb/test_bus_write_strobe.sv
`timescale 1ns/1ps
module test_bus_write_strobe;

    localparam int START_DLY = 2;
    localparam int WE_LEN    = 9;
    localparam int WE_FIRST  = START_DLY + 3;
    localparam int WE_LAST   = START_DLY + 2 + WE_LEN;
    localparam int LOAD_K    = START_DLY + WE_LEN + 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        phi2_i;
    logic        rw_i;
    logic [15:0] addr_i;
    logic [7:0]  data_i;
    logic        ce_n_o, oe_n_o, we_n_o;
    logic [21:0] mem_addr_o;
    logic [7:0]  bank_o;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [7:0]  exp_bank;

    always #2.5 clk = ~clk;

    bus_write_strobe #(.START_DLY(START_DLY), .WE_LEN(WE_LEN)) i_bus_write_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi2_i     (phi2_i),
        .rw_i       (rw_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .ce_n_o     (ce_n_o),
        .oe_n_o     (oe_n_o),
        .we_n_o     (we_n_o),
        .mem_addr_o (mem_addr_o),
        .bank_o     (bank_o)
    );

    function automatic bit f_mem(input logic [15:0] a);
        return a[15:14] == 2'b01;
    endfunction

    function automatic bit f_io(input logic [15:0] a);
        return a[15:8] == 8'hD5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one bus cycle: PHI2 high for hi fast edges, low for lo fast edges
    task automatic bus_cycle(input logic [15:0] a, input bit rd, input int hi,
                             input int lo, input bit glitch);
        logic [7:0] d_early, d_late;
        bit         act, long_hi;
        string      wtag;
        d_early = 8'($urandom);
        d_late  = d_early ^ 8'h5A;
        addr_i  = a;
        rw_i    = rd;
        data_i  = d_early;
        phi2_i  = 1'b1;
        long_hi = (hi >= LOAD_K - 2);
        wtag    = (!f_mem(a) || rd) ? "R8 we_n" : (long_hi ? "R3 we_n" : "R7 we_n");
        for (int k = 1; k <= hi + lo; k++) begin
            @(posedge clk);
            @(negedge clk);
            act = (k >= 3) && (k <= hi + 2);
            if (k == LOAD_K && long_hi && !rd && f_io(a))
                exp_bank = d_late;
            chk(k <= 3 ? "R2 ce_n" : "R9 ce_n", 32'(ce_n_o), 32'(!(act && f_mem(a))));
            chk(rd ? "R9 oe_n" : "R8 oe_n", 32'(oe_n_o), 32'(!(act && f_mem(a) && rd)));
            chk(wtag, 32'(we_n_o),
                32'(!(act && f_mem(a) && !rd && k >= WE_FIRST && k <= WE_LAST)));
            chk(long_hi ? "R6 bank" : "R7 bank", 32'(bank_o), 32'(exp_bank));
            if (!ce_n_o)
                chk("R5 mem_addr", 32'(mem_addr_o), 32'({exp_bank, a[13:0]}));
            if (k == LOAD_K && hi >= LOAD_K && f_mem(a) && !rd)
                chk("R4 strobe released under PHI2 high", 32'({phi2_i, we_n_o}), 32'(2'b11));
            if (k == hi) phi2_i = 1'b0;
            if (k == START_DLY + 4) data_i = d_late;
            if (glitch && k == 7) addr_i = 16'($urandom);
        end
    endtask

    function automatic logic [15:0] pick_addr(input int region);
        logic [15:0] r;
        r = 16'($urandom);
        case (region)
            0:       return {2'b01, r[13:0]};
            1:       return {8'hD5, r[7:0]};
            default: return {2'b00, r[13:0]};
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n    = 1'b0;
        phi2_i   = 1'b0;
        rw_i     = 1'b1;
        addr_i   = 16'h4000;
        data_i   = 8'h00;
        exp_bank = 8'h00;
        repeat (2) @(negedge clk);
        phi2_i = 1'b1;
        rw_i   = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state, with PHI2 high and a write pending
        chk("R1 ce_n", 32'(ce_n_o), 32'd1);
        chk("R1 oe_n", 32'(oe_n_o), 32'd1);
        chk("R1 we_n", 32'(we_n_o), 32'd1);
        chk("R1 bank", 32'(bank_o), 32'd0);
        phi2_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed corner cases
        bus_cycle(16'hD512, 1'b0, LOAD_K - 3, 4, 1'b0);   // R7: one short of load
        bus_cycle(16'hD534, 1'b0, LOAD_K - 2, 4, 1'b0);   // R6: just long enough
        bus_cycle(16'h4ABC, 1'b0, 20, 5, 1'b0);           // R3/R4 full write
        bus_cycle(16'h7001, 1'b0, LOAD_K - 3, 4, 1'b0);   // R7 write truncated at end
        bus_cycle(16'h5555, 1'b0, 4, 3, 1'b0);            // R7 write cut mid window
        bus_cycle(16'h4002, 1'b0, 2, 3, 1'b0);            // R7 aborted in delay
        bus_cycle(16'h6123, 1'b1, 18, 4, 1'b1);           // R9 read, R5 glitch
        bus_cycle(16'hD5FF, 1'b1, 18, 4, 1'b0);           // R8 read of I/O page
        bus_cycle(16'h8123, 1'b0, 18, 4, 1'b0);           // R8 outside window
        bus_cycle(16'hD577, 1'b0, 18, 3, 1'b1);           // R5/R6 glitch during load
        bus_cycle(16'h4321, 1'b0, 18, 3, 1'b1);           // R5 bank in mem_addr

        // constrained random cycles
        for (int n = 0; n < 60; n++) begin
            int region, hi, lo;
            bit rd, gl;
            region = int'($urandom % 3);
            rd     = 1'($urandom);
            hi     = ($urandom % 10 < 7) ? 14 + int'($urandom % 9) : 1 + int'($urandom % 13);
            lo     = 3 + int'($urandom % 6);
            gl     = ($urandom % 4) == 0;
            bus_cycle(pick_addr(region), rd, hi, lo, gl);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule